// File: doc/BRIEF.md
# Sequence-Locked Byte Store Controller

This block sits between a small CPU register bus and a byte-wide nonvolatile data array. Software reaches it through four byte registers: a location pointer, a data byte, a control/status byte and a write-only key port. A read is requested by setting a strobe bit in the control byte. The addressed array byte lands in the data byte on the clock edge that takes the request, so software can read it in the very next cycle.

Programming a byte is deliberately awkward. Write-enable must already be on. Then software must put 0x55 and then 0xAA into the key port, and set the start bit in the control byte, on three back-to-back bus cycles. A wrong key, an idle or foreign cycle between the steps, a missing write-enable, or a power-up hold window that has not yet run out each refuses the start. The array is not touched, and an error bit records the refusal. An accepted write latches the location and the data byte. It keeps the start bit high for a parameterised number of cycles, then commits the byte, drops the start bit and raises a sticky completion flag. The interrupt line is that flag gated by an enable bit.

Register offsets on `bus_addr`: 0 pointer, 1 data, 2 control, 3 key. Control bit positions: 0 read strobe (reads back 0), 1 write-enable, 2 write start/busy, 3 error, 4 completion flag, 5 interrupt enable. Bits 6 and 7 read as 0. The key port reads as 0.

Top module: `eectl_top`

## Requirements
- R1: After reset, the control byte reads 0x00, the data byte reads 0x00 and `irq` is low. Write-enable is therefore clear.
- R2: When a control write sets bit 0 while no write is busy, the data byte holds the array byte at the pointer in the cycle after that write. Control bit 0 always reads 0.
- R3: The data byte keeps its value across pointer changes and idle cycles. It changes only on an accepted read or a CPU write to offset 1.
- R4: A write starts only when key writes of 0x55 and then 0xAA, followed by a control write with bit 2 set, occupy three consecutive cycles. A wrong key value, or any extra cycle between the steps, prevents the start.
- R5: A start request is refused when write-enable (bit 1) is clear before the request. This holds even when the request itself writes bit 1 as 1.
- R6: Clearing write-enable while a write is busy does not abort it: the byte is still committed.
- R7: An accepted write keeps control bit 2 set for exactly WR_CYCLES cycles. It then commits the latched data byte to the latched location, clears bit 2 and sets bit 4.
- R8: Bit 4 stays set until a control write carries 0 in bit 4 (a 1 there leaves it unchanged). Hardware never clears write-enable.
- R9: No write starts during the first PUP_CYCLES cycles after reset.
- R10: A read request made while a write is busy is ignored: the data byte is unchanged.
- R11: `irq` is high exactly when control bits 4 and 5 are both set.
- R12: A refused start request sets bit 3. A control write carrying 0 in bit 3 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| irq | output | 1 | Completion interrupt |
| mem_addr | output | AW | Array location: the pointer when idle, the latched location when busy |
| mem_rdata | input | 8 | Array byte at `mem_addr` |
| mem_wdata | output | 8 | Latched byte to program |
| mem_commit | output | 1 | One-cycle pulse: array stores `mem_wdata` at `mem_addr` on this edge |

## Verification
The assertions assume that the array returns the byte at `mem_addr` combinationally within the same cycle. They also assume that the bus presents at most one access per cycle, which holds because the bus carries a single select. The stimulus meets both: the behavioural array is a plain indexed lookup, and every bus task drives one access between falling edges. The tasks never request a new start while a write is busy.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
   typedef enum logic [1:0] {
      RG_PTR  = 2'd0,
      RG_DATA = 2'd1,
      RG_CTRL = 2'd2,
      RG_KEY  = 2'd3
   } reg_sel_t;

   typedef enum logic [1:0] {
      UL_IDLE   = 2'd0,
      UL_FIRST  = 2'd1,
      UL_SECOND = 2'd2
   } ul_state_t;

   localparam int unsigned B_RD   = 0;
   localparam int unsigned B_WEN  = 1;
   localparam int unsigned B_GO   = 2;
   localparam int unsigned B_ERR  = 3;
   localparam int unsigned B_DONE = 4;
   localparam int unsigned B_IE   = 5;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/eectl_unlock.sv
module eectl_unlock
   import eectl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_val,
   input  logic       go_req,
   output logic       seq_ok
);
   ul_state_t st_q, st_d;

   always_comb begin
      st_d = UL_IDLE;
      if (key_wr && key_val == KEY_FIRST)
         st_d = UL_FIRST;
      else if (st_q == UL_FIRST && key_wr && key_val == KEY_SECOND)
         st_d = UL_SECOND;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= UL_IDLE;
      else        st_q <= st_d;
   end

   assign seq_ok = (st_q == UL_SECOND) && go_req;

   // R4: the second stage is reached only directly from the first
   p_second_after_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == UL_SECOND) |-> ($past(st_q) == UL_FIRST));
   // R4: the first stage needs the first key on the preceding cycle
   p_first_after_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == UL_FIRST) |-> $past(key_wr && key_val == KEY_FIRST));
endmodule

// File: rtl/eectl_pup_timer.sv
module eectl_pup_timer #(
   parameter int unsigned PUP_CYCLES = 8_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   localparam int unsigned CW = (PUP_CYCLES < 2) ? 1 : $clog2(PUP_CYCLES + 1);

   generate
      if (PUP_CYCLES == 0) begin : g_none
         assign ready = 1'b1;
      end else begin : g_cnt
         logic [CW-1:0] cnt_q;
         logic          rdy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!rdy_q) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(PUP_CYCLES - 1)) rdy_q <= 1'b1;
            end
         end
         assign ready = rdy_q;

         // R9: once open, the hold window never closes again
         p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_q |=> rdy_q);
      end
   endgenerate
endmodule

// File: rtl/eectl_wr_timer.sv
module eectl_wr_timer #(
   parameter int unsigned WR_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic commit
);
   localparam int unsigned CW = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);

   generate
      if (WR_CYCLES < 1) begin : g_bad
         $error("eectl_wr_timer: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(WR_CYCLES - 1);
      end
   end

   assign busy   = busy_q;
   assign commit = busy_q && (cnt_q == '0);

   // R7: busy persists until the count runs out
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> busy_q);
   // R7: the commit pulse ends the busy period
   p_commit_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy_q);
endmodule

// File: rtl/eectl_top.sv
module eectl_top
   import eectl_pkg::*;
#(
   parameter int unsigned AW         = 8,
   parameter int unsigned WR_CYCLES  = 32,
   parameter int unsigned PUP_CYCLES = 8_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic [7:0]    bus_wdata,
   output logic [7:0]    bus_rdata,
   output logic          irq,
   output logic [AW-1:0] mem_addr,
   input  logic [7:0]    mem_rdata,
   output logic [7:0]    mem_wdata,
   output logic          mem_commit
);
   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("eectl_top: AW must lie in 1..8");
      end
   endgenerate

   logic          wr_acc, ptr_wr, data_wr, ctrl_wr, key_wr;
   logic          rd_req, go_req, seq_ok, pup_ok, start, reject;
   logic          busy, commit;
   logic [AW-1:0] ptr_q, wa_q;
   logic [7:0]    data_q, wd_q;
   logic          wen_q, ie_q, err_q, done_q;

   assign wr_acc  = bus_sel && bus_we;
   assign ptr_wr  = wr_acc && (bus_addr == RG_PTR);
   assign data_wr = wr_acc && (bus_addr == RG_DATA);
   assign ctrl_wr = wr_acc && (bus_addr == RG_CTRL);
   assign key_wr  = wr_acc && (bus_addr == RG_KEY);
   assign rd_req  = ctrl_wr && bus_wdata[B_RD];
   assign go_req  = ctrl_wr && bus_wdata[B_GO];

   eectl_unlock u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_wr  (key_wr),
      .key_val (bus_wdata),
      .go_req  (go_req),
      .seq_ok  (seq_ok)
   );

   eectl_pup_timer #(.PUP_CYCLES(PUP_CYCLES)) u_pup (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (pup_ok)
   );

   assign start  = seq_ok && wen_q && pup_ok && !busy;
   assign reject = go_req && !start;

   eectl_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .commit (commit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         data_q <= '0;
         wa_q   <= '0;
         wd_q   <= '0;
      end else begin
         if (ptr_wr) ptr_q <= bus_wdata[AW-1:0];
         if (rd_req && !busy) data_q <= mem_rdata;
         else if (data_wr)    data_q <= bus_wdata;
         if (start) begin
            wa_q <= ptr_q;
            wd_q <= data_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q  <= 1'b0;
         ie_q   <= 1'b0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            wen_q <= bus_wdata[B_WEN];
            ie_q  <= bus_wdata[B_IE];
         end
         if (reject)                           err_q <= 1'b1;
         else if (ctrl_wr && !bus_wdata[B_ERR]) err_q <= 1'b0;
         if (commit)                            done_q <= 1'b1;
         else if (ctrl_wr && !bus_wdata[B_DONE]) done_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RG_PTR:  bus_rdata[AW-1:0] = ptr_q;
         RG_DATA: bus_rdata = data_q;
         RG_CTRL: bus_rdata = {2'b00, ie_q, done_q, err_q, busy, wen_q, 1'b0};
         default: bus_rdata = '0;
      endcase
   end

   assign irq        = done_q && ie_q;
   assign mem_addr   = busy ? wa_q : ptr_q;
   assign mem_wdata  = wd_q;
   assign mem_commit = commit;

   // R5: a write begins only with write-enable already on
   p_start_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wen_q));
   // R9: no write begins inside the hold window
   p_start_pup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(pup_ok));
   // R8: completion flag is sticky
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(ctrl_wr && !bus_wdata[B_DONE])) |=> done_q);
   // R8: write-enable changes only by a control write
   p_wen_hw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wen_q && !ctrl_wr) |=> wen_q);
   // R10: data byte is frozen during a write unless the CPU writes it
   p_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !data_wr) |=> $stable(data_q));
   // R6: a running write continues whatever happens to write-enable
   p_no_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !commit) |=> busy);
endmodule

// File: tb/sim_eectl_top.sv
module sim_eectl_top;
   localparam int AW  = 8;
   localparam int WRC = 6;
   localparam int PUP = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_rdata, mem_wdata;
   logic       mem_commit;
   logic [7:0] mem [256];

   int checks = 0, errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   eectl_top #(.AW(AW), .WR_CYCLES(WRC), .PUP_CYCLES(PUP)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_commit(mem_commit)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_commit) mem[mem_addr] <= mem_wdata;

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic unlock(input logic [7:0] k1, input logic [7:0] k2,
                         input int g1, input int g2, input logic [7:0] c);
      wr(2'd3, k1); idle(g1);
      wr(2'd3, k2); idle(g2);
      wr(2'd2, c);
   endtask

   // control values: wen=0x02, go=0x04, ie=0x20
   task automatic t_reset;
      logic [7:0] v;
      rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
      rd(2'd1, v); chk("R1 data", v, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_powerup;
      logic [7:0] v;
      wr(2'd0, 8'h11); wr(2'd1, 8'hEE); wr(2'd2, 8'h02);
      unlock(8'h55, 8'hAA, 0, 0, 8'h06);
      rd(2'd2, v); chk("R9 no start in hold window", v, 8'h0A);
      chk("R12 err set on refusal", v & 8'h08, 8'h08);
      idle(WRC + 1);
      chk("R9 array untouched", mem[8'h11], 8'h11 ^ 8'h5A);
      wr(2'd2, 8'h02);
      rd(2'd2, v); chk("R12 err cleared", v, 8'h02);
   endtask

   task automatic t_read;
      logic [7:0] v;
      wr(2'd0, 8'h10); wr(2'd2, 8'h03);
      rd(2'd1, v); chk("R2 data next cycle", v, 8'h10 ^ 8'h5A);
      rd(2'd2, v); chk("R2 strobe reads 0", v, 8'h02);
   endtask

   task automatic t_hold;
      logic [7:0] v;
      wr(2'd0, 8'h99); idle(3);
      rd(2'd1, v); chk("R3 hold over pointer change", v, 8'h10 ^ 8'h5A);
      wr(2'd1, 8'h77);
      rd(2'd1, v); chk("R3 cpu write", v, 8'h77);
   endtask

   task automatic t_write;
      logic [7:0] v;
      wr(2'd0, 8'h20); wr(2'd1, 8'hC3);
      unlock(8'h55, 8'hAA, 0, 0, 8'h06);
      idle(WRC - 1);
      rd(2'd2, v); chk("R7 busy on last cycle", v, 8'h06);
      chk("R11 irq low with ie clear", {7'd0, irq}, 8'h00);
      idle(1);
      rd(2'd2, v); chk("R7 done after WR_CYCLES", v, 8'h12);
      chk("R7 array committed", mem[8'h20], 8'hC3);
      chk("R11 irq low with ie clear after done", {7'd0, irq}, 8'h00);
      wr(2'd2, 8'h32);
      chk("R11 irq high", {7'd0, irq}, 8'h01);
      wr(2'd2, 8'h03);
      rd(2'd1, v); chk("R7 readback", v, 8'hC3);
   endtask

   task automatic t_sticky;
      logic [7:0] v;
      unlock(8'h55, 8'hAA, 0, 0, 8'h16);
      idle(WRC + 4);
      rd(2'd2, v); chk("R8 done sticky", v, 8'h12);
      wr(2'd2, 8'h12);
      rd(2'd2, v); chk("R8 writing 1 keeps done", v, 8'h12);
      wr(2'd2, 8'h02);
      rd(2'd2, v); chk("R8 done cleared, wen kept", v, 8'h02);
   endtask

   task automatic t_badseq;
      logic [7:0] v;
      wr(2'd0, 8'h50); wr(2'd1, 8'h01);
      unlock(8'h55, 8'hAB, 0, 0, 8'h06);
      rd(2'd2, v); chk("R4 wrong key refused", v, 8'h0A);
      wr(2'd2, 8'h02);
      unlock(8'h55, 8'hAA, 1, 0, 8'h06);
      rd(2'd2, v); chk("R4 gap before second key", v, 8'h0A);
      wr(2'd2, 8'h02);
      unlock(8'h55, 8'hAA, 0, 1, 8'h06);
      rd(2'd2, v); chk("R4 gap before start", v, 8'h0A);
      wr(2'd2, 8'h02);
      idle(WRC + 1);
      chk("R4 array untouched", mem[8'h50], 8'h50 ^ 8'h5A);
   endtask

   task automatic t_nowen;
      logic [7:0] v;
      wr(2'd0, 8'h60); wr(2'd2, 8'h00);
      unlock(8'h55, 8'hAA, 0, 0, 8'h06);
      rd(2'd2, v); chk("R5 refused without wen", v, 8'h0A);
      idle(WRC + 1);
      chk("R5 array untouched", mem[8'h60], 8'h60 ^ 8'h5A);
      wr(2'd2, 8'h02);
   endtask

   task automatic t_abort;
      logic [7:0] v;
      wr(2'd0, 8'h70); wr(2'd1, 8'h3C);
      unlock(8'h55, 8'hAA, 0, 0, 8'h06);
      wr(2'd2, 8'h00);
      rd(2'd2, v); chk("R6 still busy after wen clear", v, 8'h04);
      idle(WRC);
      chk("R6 committed", mem[8'h70], 8'h3C);
      wr(2'd2, 8'h02);
   endtask

   task automatic t_rdbusy;
      logic [7:0] v;
      wr(2'd0, 8'h30); wr(2'd1, 8'hA5);
      unlock(8'h55, 8'hAA, 0, 0, 8'h06);
      wr(2'd0, 8'h40); wr(2'd2, 8'h03);
      rd(2'd1, v); chk("R10 read during busy ignored", v, 8'hA5);
      idle(WRC);
      chk("R10 write used latched location", mem[8'h30], 8'hA5);
      chk("R10 other location intact", mem[8'h40], 8'h40 ^ 8'h5A);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      idle(2);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_powerup();
      idle(PUP);
      t_read();
      t_hold();
      t_write();
      t_sticky();
      t_badseq();
      t_nowen();
      t_abort();
      t_rdbusy();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule